// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs one conversion at a time on an external eight-input, 8-bit successive-approximation converter. A host gives it a 3-bit channel number and a one-cycle start request. The sequencer then drives the channel onto the converter's address lines and waits a programmable set-up time. It raises a hold line to an external sample-and-hold and sends a start pulse of programmable width. After that it waits for the converter's end-of-conversion signal. That signal is taken through a two-stage synchroniser and edge detector, so a level left high by an earlier conversion cannot end a new one.

When the rising edge arrives, the 8-bit unipolar code is latched. It is reported with a one-cycle valid strobe and the channel it came from. If no edge arrives within a programmable number of cycles, hold is released and a one-cycle timeout flag replaces the result. The set-up, pulse and timeout limits are all parameters, so one design covers fast converters and ones that take hundreds of milliseconds.

Top module: `adc_conv_sequencer`

## Requirements
- R1: During and right after synchronous reset, busy_o, soc_o, hold_o, res_valid_o and timeout_o are low, and addr_o, res_data_o and res_chan_o are zero.
- R2: An accepted request puts chan_i on addr_o in binary, with bit 0 as the least significant select line (channel 2 gives addr_o = 3'b010). addr_o stays unchanged until the conversion ends with a result or a timeout.
- R3: soc_o first goes high exactly SETUP_CYC cycles after the cycle in which busy_o first goes high.
- R4: soc_o stays high for exactly SOC_CYC consecutive cycles in each conversion.
- R5: hold_o is high in every cycle from the first soc_o cycle until the conversion ends. It is low in the cycle that carries the valid strobe or the timeout flag.
- R6: eoc_i passes through two flip-flops before its rising edge is detected. res_valid_o is high in the third cycle after the cycle in which eoc_i first reads high.
- R7: An eoc_i level that is already high when the conversion starts, with no new rising edge, does not end the conversion. The conversion ends in a timeout instead.
- R8: res_valid_o is high for exactly one cycle per completed conversion. In that cycle res_data_o holds the converter code and res_chan_o holds the channel. Both keep their values until the next completed conversion, including across a timeout.
- R9: A start request that arrives while busy_o is high is ignored. addr_o and the reported channel stay those of the request already accepted.
- R10: busy_o is high from the cycle after an accepted request through the strobe cycle, and low in the cycle after the strobe.
- R11: If no eoc_i rising edge is seen within TIMEOUT_CYC cycles of waiting, timeout_o is high for one cycle without res_valid_o. That happens SETUP_CYC + SOC_CYC + TIMEOUT_CYC cycles after busy_o first goes high, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken while idle |
| chan_i | input | 3 | Channel number for the request |
| eoc_i | input | 1 | End of conversion from converter (asynchronous) |
| adc_data_i | input | 8 | Converter parallel output code |
| addr_o | output | 3 | Channel select lines to the converter |
| hold_o | output | 1 | Hold command to the sample-and-hold |
| soc_o | output | 1 | Start-of-conversion pulse |
| busy_o | output | 1 | Conversion in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 8 | Latched conversion code |
| res_chan_o | output | 3 | Channel tag of the latched code |
| timeout_o | output | 1 | One-cycle timeout flag |

## Verification
The bench builds the block with SETUP_CYC = 3, SOC_CYC = 2 and TIMEOUT_CYC = 40. Because the timeout is that short, both timeout cases fit in a few dozen cycles: a converter that never answers, and an end-of-conversion level left high from the previous run. A converter delay of 38 cycles places the edge one cycle before the timeout limit. The set-up and pulse widths are larger than one, so their exact counts tell a correct sequencer apart from one that is off by a cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W = 3;
    localparam int CODE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SOC,
        ST_WAIT,
        ST_DONE,
        ST_TOUT
    } seq_state_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } conv_result_t;

    function automatic int count_width(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/eoc_edge_sync.sv
module eoc_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~last_q;

    // R7
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/seq_cycle_timer.sv
module seq_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            count_o <= '0;
        else if (count_o != TOP)
            count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/result_latch.sv
module result_latch
    import adc_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  conv_result_t d_i,
    output conv_result_t q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int SETUP_CYC   = 4,
    parameter int SOC_CYC     = 3,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              eoc_i,
    input  logic [CODE_W-1:0] adc_data_i,
    output logic [CHAN_W-1:0] addr_o,
    output logic              hold_o,
    output logic              soc_o,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [CODE_W-1:0] res_data_o,
    output logic [CHAN_W-1:0] res_chan_o,
    output logic              timeout_o
);
    localparam int CNT_W = count_width(SETUP_CYC, SOC_CYC, TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] SOC_LAST   = CNT_W'(SOC_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic              eoc_rise;
    logic [CHAN_W-1:0] addr_q;
    conv_result_t      res_d, res_q;

    eoc_edge_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (eoc_i),
        .rise_o  (eoc_rise)
    );

    seq_cycle_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (state_d != state_q),
        .count_o (cnt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: if (cnt == SETUP_LAST) state_d = ST_SOC;
            ST_SOC:   if (cnt == SOC_LAST) state_d = ST_WAIT;
            ST_WAIT: begin
                if (eoc_rise)               state_d = ST_DONE;
                else if (cnt == WAIT_LAST)  state_d = ST_TOUT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_TOUT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i)
                addr_q <= chan_i;
        end
    end

    assign res_d = '{chan: addr_q, code: adc_data_i};

    result_latch u_res (
        .clk    (clk),
        .rst    (rst),
        .load_i (state_q == ST_WAIT && eoc_rise),
        .d_i    (res_d),
        .q_o    (res_q)
    );

    assign addr_o      = addr_q;
    assign soc_o       = (state_q == ST_SOC);
    assign hold_o      = (state_q == ST_SOC) || (state_q == ST_WAIT);
    assign busy_o      = (state_q != ST_IDLE);
    assign res_valid_o = (state_q == ST_DONE);
    assign timeout_o   = (state_q == ST_TOUT);
    assign res_data_o  = res_q.code;
    assign res_chan_o  = res_q.chan;

    // soc pulse length counter for checking
    logic [CNT_W-1:0] soc_len;
    always_ff @(posedge clk) begin
        if (rst || !soc_o) soc_len <= '0;
        else               soc_len <= soc_len + 1'b1;
    end

    // R4
    soc_width_chk: assert property (@(posedge clk) disable iff (rst)
        (soc_o && soc_len == SOC_LAST) |=> !soc_o);

    // R5
    hold_covers_soc_chk: assert property (@(posedge clk) disable iff (rst)
        soc_o |-> hold_o);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    // R11
    tout_excl_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!res_valid_o && !hold_o));

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(addr_o));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !busy_o);

endmodule

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;

    localparam int SETUP = 3;
    localparam int SOCW  = 2;
    localparam int TOUT  = 40;
    localparam int NV    = 7;
    // modes: 0 normal, 1 never answers, 2 stale-high EOC, 3 normal with busy poke
    localparam int V_CH  [NV] = '{2, 0, 7, 3, 5, 4, 6};
    localparam int V_DLY [NV] = '{5, 1, 38, 0, 0, 10, 20};
    localparam int V_MODE[NV] = '{0, 0, 0, 2, 1, 3, 0};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       eoc_i = 1'b1;
    logic [7:0] adc_data_i = '0;
    logic [2:0] addr_o;
    logic       hold_o, soc_o, busy_o, res_valid_o, timeout_o;
    logic [7:0] res_data_o;
    logic [2:0] res_chan_o;

    int tests = 0;
    int fails = 0;
    int stub_mode = 0;
    int stub_dly = 5;
    logic [7:0] last_code = '0;
    logic [2:0] last_chan = '0;

    always #5 clk = ~clk;

    adc_conv_sequencer #(.SETUP_CYC(SETUP), .SOC_CYC(SOCW), .TIMEOUT_CYC(TOUT)) i_adc_conv_sequencer (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .eoc_i(eoc_i),
        .adc_data_i(adc_data_i), .addr_o(addr_o), .hold_o(hold_o), .soc_o(soc_o),
        .busy_o(busy_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
        .res_chan_o(res_chan_o), .timeout_o(timeout_o)
    );

    function automatic logic [7:0] code_of(input logic [2:0] c);
        return 8'((int'(c) * 37 + 11) % 256);
    endfunction

    // behavioural converter
    initial begin
        forever begin
            @(posedge soc_o);
            if (stub_mode != 2) eoc_i <= 1'b0;
            if (stub_mode == 0 || stub_mode == 3) begin
                repeat (stub_dly) @(posedge clk);
                adc_data_i <= code_of(addr_o);
                eoc_i <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_idle_reset();
        chk(!busy_o && !soc_o && !hold_o, "R1 ctrl", {busy_o, soc_o, hold_o}, 0);
        chk(!res_valid_o && !timeout_o, "R1 flags", {res_valid_o, timeout_o}, 0);
        chk(addr_o == 0 && res_data_o == 0 && res_chan_o == 0, "R1 data",
            {addr_o, res_chan_o, res_data_o}, 0);
    endtask

    task automatic run_conv(input int ch, input int dly, input int mode);
        int setup_n = 0, soc_n = 0, end_n = -1, eoc_n = -1;
        bit seen_soc = 0, addr_bad = 0, busy_bad = 0, hold_bad = 0, got_v = 0, got_t = 0;
        bit end_hold = 0, prev_eoc;
        stub_mode = mode;
        stub_dly = dly;
        @(negedge clk);
        chan_i = 3'(ch);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        prev_eoc = eoc_i;
        for (int n = 0; n < 200; n++) begin
            if (!busy_o) busy_bad = 1;
            if (addr_o != 3'(ch)) addr_bad = 1;
            if (eoc_i && !prev_eoc && eoc_n < 0) eoc_n = n;
            prev_eoc = eoc_i;
            if (res_valid_o || timeout_o) begin
                got_v = res_valid_o;
                got_t = timeout_o;
                end_hold = hold_o;
                end_n = n;
                break;
            end
            if (soc_o) begin
                soc_n++;
                seen_soc = 1;
            end else if (!seen_soc) setup_n++;
            if (seen_soc && !hold_o) hold_bad = 1;
            if (mode == 3 && soc_n == 1 && soc_o) begin
                start_i = 1'b1;
                chan_i = 3'(ch) ^ 3'd7;
            end else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(setup_n == SETUP, "R3 setup", setup_n, SETUP);
        chk(soc_n == SOCW, "R4 soc width", soc_n, SOCW);
        chk(!hold_bad && !end_hold, "R5 hold span", {hold_bad, end_hold}, 0);
        chk(!addr_bad, "R2 addr stable", addr_bad, 0);
        if (mode == 3) chk(!addr_bad && res_chan_o == 3'(ch), "R9 busy request ignored", res_chan_o, ch);
        if (mode == 0 || mode == 3) begin
            chk(got_v && !got_t, "R8 valid strobe", {got_v, got_t}, 2);
            chk(res_data_o == code_of(3'(ch)) && res_chan_o == 3'(ch), "R8 data/chan",
                {res_chan_o, res_data_o}, {3'(ch), code_of(3'(ch))});
            chk(end_n - eoc_n == 3, "R6 eoc latency", end_n - eoc_n, 3);
            last_code = code_of(3'(ch));
            last_chan = 3'(ch);
        end else begin
            chk(got_t && !got_v, mode == 2 ? "R7 stale eoc timeout" : "R11 timeout flag",
                {got_v, got_t}, 1);
            chk(end_n == SETUP + SOCW + TOUT, "R11 timeout cycle", end_n, SETUP + SOCW + TOUT);
            chk(res_data_o == last_code && res_chan_o == last_chan, "R8 held across timeout",
                res_data_o, last_code);
        end
        chk(!busy_bad, "R10 busy during", busy_bad, 0);
        @(negedge clk);
        chk(!busy_o && !res_valid_o && !timeout_o, "R10 busy/flags drop",
            {busy_o, res_valid_o, timeout_o}, 0);
        chk(res_data_o == last_code && res_chan_o == last_chan, "R8 result held",
            res_data_o, last_code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle_reset();
        rst = 1'b0;
        @(negedge clk);
        check_idle_reset();
        for (int i = 0; i < NV; i++) run_conv(V_CH[i], V_DLY[i], V_MODE[i]);
        // reset in the middle of a conversion
        stub_mode = 1;
        @(negedge clk);
        chan_i = 3'd6;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle_reset();
        rst = 1'b0;
        @(negedge clk);
        check_idle_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule